// File: doc/BRIEF.md
# Serial port sample rate generator

This block derives a bit clock and a frame-sync pulse train for a serial port. Everything runs on the core clock `clk_i`. The input clock is either the core clock itself, where every core cycle counts as one input tick, or an external clock pin. The external pin is synchronised, and each of its rising edges counts as one input tick. A divider turns input ticks into CLKG cycles. It marks the start of each CLKG cycle with a one-core-cycle strobe, `clkg_edge_o`.

The frame generator counts CLKG cycles to build FSG, an active-high pulse with a programmable width and period. When the external clock is selected and external sync mode is on, a rising edge on the receive frame-sync pin restarts the divider phase and starts a frame. In that mode the external device sets the frame period.

Two selectors finish the block. The receive frame sync comes from FSG or from the receive pin. The transmit frame sync comes from one of three sources: the transmit pin, FSG, or a strobe that marks each transfer from the transmit buffer to the shifter.

Top module: `serial_rate_gen`

## Requirements
- R1: With `ext_sel_i`=0 every core cycle is an input tick. With `ext_sel_i`=1 an input tick is each rising edge of `ext_clk_i`, seen after a two-flop synchroniser.
- R2: While enabled, `clkg_edge_o` is high for one core cycle once every (`clk_div_i`+1) input ticks, one cycle after the tick that closes the count. With `clk_div_i`=0 every input tick gives a strobe.
- R3: `fsg_o` changes only in cycles where `clkg_edge_o` is high. Each pulse stays high for (`fs_wid_i`+1) CLKG cycles.
- R4: Without external sync, successive FSG pulses start (`fs_per_i`+1) CLKG cycles apart. The first pulse starts at the first CLKG cycle after the frame logic is enabled.
- R5: If `fs_wid_i` >= `fs_per_i`, each pulse is cut at the next period start, so `fsg_o` stays high.
- R6: `sync_ext_i` has no effect while `ext_sel_i`=0.
- R7: With `sync_ext_i`=1 and `ext_sel_i`=1, a rising edge of `fsr_i` is detected after a two-flop synchroniser clocked by input ticks. That tick then becomes a CLKG cycle start, the divider restarts from zero, and a new FSG pulse starts. No other FSG pulse starts, and `fs_per_i` is ignored.
- R8: While `gen_en_i`=0, `clkg_edge_o` and `fsg_o` are 0 and both counters are cleared. After reset both outputs are 0.
- R9: While `frame_en_i`=0, `fsg_o` is 0 and the frame restarts when the frame logic is enabled again.
- R10: `rx_fs_o` equals `fsg_o` when `rx_fs_int_i`=1, and equals `fsr_i` otherwise.
- R11: `tx_fs_o` depends on two selects. It equals `fsx_i` when `tx_fs_int_i`=0. It equals `fsg_o` when `tx_fs_int_i`=1 and `tx_fs_gen_i`=1. It equals `xfer_i` when `tx_fs_int_i`=1 and `tx_fs_gen_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gen_en_i | input | 1 | Generator enable |
| frame_en_i | input | 1 | Frame-sync logic enable |
| ext_sel_i | input | 1 | Select the external clock as the input clock |
| ext_clk_i | input | 1 | External clock pin |
| sync_ext_i | input | 1 | Resynchronise to external frame-sync edges |
| clk_div_i | input | 8 | CLKG divide value minus one |
| fs_per_i | input | 12 | Frame period minus one, in CLKG cycles |
| fs_wid_i | input | 8 | Frame pulse width minus one, in CLKG cycles |
| fsr_i | input | 1 | Receive frame-sync pin |
| fsx_i | input | 1 | Transmit frame-sync pin |
| rx_fs_int_i | input | 1 | Receive frame sync from FSG |
| tx_fs_int_i | input | 1 | Transmit frame sync generated internally |
| tx_fs_gen_i | input | 1 | Internal transmit frame sync comes from FSG rather than buffer loads |
| xfer_i | input | 1 | Transmit buffer-to-shifter transfer strobe |
| clkg_edge_o | output | 1 | Strobe at the start of each CLKG cycle |
| fsg_o | output | 1 | Generated frame sync |
| rx_fs_o | output | 1 | Selected receive frame sync |
| tx_fs_o | output | 1 | Selected transmit frame sync |

## Verification
With the core clock selected, `clkg_edge_o` and `fsg_o` are due one cycle after the edge on which the closing tick is sampled. With the external clock selected, a pin edge reaches them three core cycles later: two synchroniser stages plus the output register. An `fsr_i` edge in external sync mode needs two more input ticks before it restarts the divider. `rx_fs_o` and `tx_fs_o` follow their inputs in the same cycle. The bench runs a behavioural model on each rising edge, using the inputs held since the previous falling edge. It compares all four outputs on the falling edge, before any input moves.

// File: rtl/srg_pkg.sv
package srg_pkg;
  typedef enum logic [1:0] {
    TXFS_PIN  = 2'd0,
    TXFS_GEN  = 2'd1,
    TXFS_LOAD = 2'd2
  } txfs_src_e;

  function automatic txfs_src_e tx_src(input logic internal, input logic from_gen);
    if (!internal) return TXFS_PIN;
    if (from_gen) return TXFS_GEN;
    return TXFS_LOAD;
  endfunction
endpackage

// File: rtl/srg_sync_edge.sv
module srg_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else if (en_i) begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = en_i & sync_q[STAGES-1] & ~prev_q;

  AST_RISE_ONESHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R7
endmodule

// File: rtl/srg_clk_div.sv
module srg_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             evt_o,
  output logic             edge_o
);
  logic [DIV_W-1:0] cnt_q;

  assign evt_o = en_i & tick_i & (restart_i | (cnt_q >= div_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      edge_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      edge_o <= 1'b0;
    end else begin
      edge_o <= evt_o;
      if (tick_i) cnt_q <= evt_o ? '0 : cnt_q + 1'b1;
    end
  end

  AST_IDLE_NO_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !edge_o); // R8
  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && div_i == '0) |=> edge_o); // R2
  AST_NO_TICK_NO_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !edge_o); // R1
endmodule

// File: rtl/srg_frame_gen.sv
module srg_frame_gen #(
  parameter int PER_W = 12,
  parameter int WID_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gen_en_i,
  input  logic             frame_en_i,
  input  logic             evt_i,
  input  logic             ext_mode_i,
  input  logic             restart_i,
  input  logic [PER_W-1:0] per_i,
  input  logic [WID_W-1:0] wid_i,
  output logic             fsg_o
);
  localparam int CNT_W = (PER_W > WID_W) ? PER_W : WID_W;

  logic [CNT_W-1:0] pos_q, pos_nxt;
  logic             run_q, run_nxt;
  logic             active;

  assign active = gen_en_i & frame_en_i;

  always_comb begin
    pos_nxt = pos_q;
    run_nxt = run_q;
    if (ext_mode_i) begin
      if (restart_i) begin
        pos_nxt = '0;
        run_nxt = 1'b1;
      end else if (run_q && pos_q != '1) begin
        pos_nxt = pos_q + 1'b1;
      end
    end else if (!run_q) begin
      pos_nxt = '0;
      run_nxt = 1'b1;
    end else begin
      pos_nxt = (pos_q >= CNT_W'(per_i)) ? '0 : pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      run_q <= 1'b0;
      fsg_o <= 1'b0;
    end else if (!active) begin
      pos_q <= '0;
      run_q <= 1'b0;
      fsg_o <= 1'b0;
    end else if (evt_i) begin
      pos_q <= pos_nxt;
      run_q <= run_nxt;
      fsg_o <= run_nxt && (pos_nxt <= CNT_W'(wid_i));
    end
  end

  AST_FSG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i && active) |=> $stable(fsg_o)); // R3
  AST_FSG_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_en_i |=> !fsg_o); // R9
  AST_EXT_START_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_mode_i && active && !run_q && !restart_i) |=> !fsg_o); // R7
endmodule

// File: rtl/serial_rate_gen.sv
module serial_rate_gen
  import srg_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int PER_W       = 12,
  parameter int WID_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gen_en_i,
  input  logic             frame_en_i,
  input  logic             ext_sel_i,
  input  logic             ext_clk_i,
  input  logic             sync_ext_i,
  input  logic [DIV_W-1:0] clk_div_i,
  input  logic [PER_W-1:0] fs_per_i,
  input  logic [WID_W-1:0] fs_wid_i,
  input  logic             fsr_i,
  input  logic             fsx_i,
  input  logic             rx_fs_int_i,
  input  logic             tx_fs_int_i,
  input  logic             tx_fs_gen_i,
  input  logic             xfer_i,
  output logic             clkg_edge_o,
  output logic             fsg_o,
  output logic             rx_fs_o,
  output logic             tx_fs_o
);
  logic      ext_rise, tick, fsr_rise, ext_mode, resync, clkg_evt;
  txfs_src_e tx_sel;

  srg_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_clk_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (1'b1),
    .d_i   (ext_clk_i),
    .rise_o(ext_rise)
  );

  assign tick = ext_sel_i ? ext_rise : 1'b1;

  // frame pin is sampled in the input clock domain
  srg_sync_edge #(.STAGES(SYNC_STAGES)) u_fsr_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (tick),
    .d_i   (fsr_i),
    .rise_o(fsr_rise)
  );

  assign ext_mode = sync_ext_i & ext_sel_i;
  assign resync   = ext_mode & fsr_rise;

  srg_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (gen_en_i),
    .tick_i   (tick),
    .restart_i(resync),
    .div_i    (clk_div_i),
    .evt_o    (clkg_evt),
    .edge_o   (clkg_edge_o)
  );

  srg_frame_gen #(.PER_W(PER_W), .WID_W(WID_W)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gen_en_i  (gen_en_i),
    .frame_en_i(frame_en_i),
    .evt_i     (clkg_evt),
    .ext_mode_i(ext_mode),
    .restart_i (resync),
    .per_i     (fs_per_i),
    .wid_i     (fs_wid_i),
    .fsg_o     (fsg_o)
  );

  assign rx_fs_o = rx_fs_int_i ? fsg_o : fsr_i;
  assign tx_sel  = tx_src(tx_fs_int_i, tx_fs_gen_i);

  always_comb begin
    unique case (tx_sel)
      TXFS_GEN:  tx_fs_o = fsg_o;
      TXFS_LOAD: tx_fs_o = xfer_i;
      default:   tx_fs_o = fsx_i;
    endcase
  end

  AST_RESYNC_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resync && gen_en_i) |=> clkg_edge_o); // R7
  AST_CORE_NO_RESYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_sel_i |-> !resync); // R6
  AST_GEN_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_en_i |=> (!clkg_edge_o && !fsg_o)); // R8
endmodule

// File: tb/serial_rate_gen_tb_top.sv
`timescale 1ns/1ps
module serial_rate_gen_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic gen_en_i = 0, frame_en_i = 0, ext_sel_i = 0, ext_clk_i = 0, sync_ext_i = 0;
  logic [7:0]  clk_div_i = 0;
  logic [11:0] fs_per_i = 0;
  logic [7:0]  fs_wid_i = 0;
  logic fsr_i = 0, fsx_i = 0, rx_fs_int_i = 0, tx_fs_int_i = 0, tx_fs_gen_i = 0, xfer_i = 0;
  logic clkg_edge_o, fsg_o, rx_fs_o, tx_fs_o;

  int checks = 0;
  int failures = 0;
  string cur_req = "R8";
  bit ext_run = 0;
  int ext_half = 3;
  int ext_cnt = 0;
  bit rand_pins = 0;
  int edge_count = 0;

  // model state
  int ext_pipe[$] = '{0, 0};
  int fsr_pipe[$] = '{0, 0};
  int e_prev = 0, f_prev = 0;
  int m_cnt = 0, m_fcnt = 0, m_run = 0, m_edge = 0, m_fsg = 0;

  always #5 clk_i = ~clk_i;

  serial_rate_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .gen_en_i(gen_en_i), .frame_en_i(frame_en_i),
    .ext_sel_i(ext_sel_i), .ext_clk_i(ext_clk_i), .sync_ext_i(sync_ext_i),
    .clk_div_i(clk_div_i), .fs_per_i(fs_per_i), .fs_wid_i(fs_wid_i),
    .fsr_i(fsr_i), .fsx_i(fsx_i), .rx_fs_int_i(rx_fs_int_i), .tx_fs_int_i(tx_fs_int_i),
    .tx_fs_gen_i(tx_fs_gen_i), .xfer_i(xfer_i), .clkg_edge_o(clkg_edge_o),
    .fsg_o(fsg_o), .rx_fs_o(rx_fs_o), .tx_fs_o(tx_fs_o)
  );

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      ext_pipe = '{0, 0}; fsr_pipe = '{0, 0};
      e_prev = 0; f_prev = 0;
      m_cnt = 0; m_fcnt = 0; m_run = 0; m_edge = 0; m_fsg = 0;
    end else begin
      int tick, fs_rise, rs, ev, pos;
      tick    = ext_sel_i ? (ext_pipe[1] && !e_prev) : 1;
      fs_rise = tick && fsr_pipe[1] && !f_prev;
      rs      = sync_ext_i && ext_sel_i && fs_rise;
      e_prev  = ext_pipe[1];
      void'(ext_pipe.pop_back());
      ext_pipe.push_front(int'(ext_clk_i));
      if (tick) begin
        f_prev = fsr_pipe[1];
        void'(fsr_pipe.pop_back());
        fsr_pipe.push_front(int'(fsr_i));
      end
      if (!gen_en_i) begin
        m_cnt = 0; m_edge = 0; m_fcnt = 0; m_run = 0; m_fsg = 0;
      end else begin
        ev = tick && (rs || m_cnt >= clk_div_i);
        if (tick) m_cnt = ev ? 0 : m_cnt + 1;
        m_edge = ev;
        if (!frame_en_i) begin
          m_fcnt = 0; m_run = 0; m_fsg = 0;
        end else if (ev) begin
          pos = m_fcnt;
          if (sync_ext_i && ext_sel_i) begin
            if (rs) begin pos = 0; m_run = 1; end
            else if (m_run && pos < 4095) pos = pos + 1;
          end else if (!m_run) begin
            pos = 0; m_run = 1;
          end else begin
            pos = (pos >= fs_per_i) ? 0 : pos + 1;
          end
          m_fcnt = pos;
          m_fsg = m_run && pos <= fs_wid_i;
        end
      end
    end
  end

  task automatic cmp(input string what, input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni || cur_req == "R8") begin
      int exp_tx;
      exp_tx = !tx_fs_int_i ? fsx_i : (tx_fs_gen_i ? m_fsg : xfer_i);
      cmp("clkg_edge_o", cur_req, clkg_edge_o, m_edge);
      cmp("fsg_o", cur_req, fsg_o, m_fsg);
      cmp("rx_fs_o R10", cur_req, rx_fs_o, rx_fs_int_i ? m_fsg : fsr_i);
      cmp("tx_fs_o R11", cur_req, tx_fs_o, exp_tx);
      if (clkg_edge_o) edge_count++;
    end
  end

  // background pin drivers
  always @(negedge clk_i) begin
    #1;
    if (ext_run) begin
      ext_cnt++;
      if (ext_cnt >= ext_half) begin ext_cnt = 0; ext_clk_i = ~ext_clk_i; end
    end
    if (rand_pins) begin
      fsr_i  = 1'($urandom);
      fsx_i  = 1'($urandom);
      xfer_i = 1'($urandom);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); #1;
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(4);
    rst_ni = 1'b1;                                   // R8 reset state checked above
    cur_req = "R2";
    clk_div_i = 0; fs_per_i = 7; fs_wid_i = 1;
    gen_en_i = 1; frame_en_i = 1; rx_fs_int_i = 1; tx_fs_int_i = 1; tx_fs_gen_i = 1;
    step(60);
    cur_req = "R3";
    clk_div_i = 3; fs_per_i = 4; fs_wid_i = 2;
    step(40);
    edge_count = 0;
    step(80);
    cmp("edge count div3", "R2", edge_count, 20);
    cur_req = "R4";
    fs_per_i = 9; fs_wid_i = 0;
    step(200);
    cur_req = "R5";
    fs_per_i = 3; fs_wid_i = 9;
    step(100);
    cur_req = "R9";
    frame_en_i = 0; step(30); frame_en_i = 1; step(60);
    cur_req = "R10";
    rand_pins = 1; fs_per_i = 5; fs_wid_i = 1; clk_div_i = 1;
    for (int s = 0; s < 8; s++) begin
      rx_fs_int_i = s[0]; tx_fs_int_i = s[1]; tx_fs_gen_i = s[2];
      cur_req = s[0] ? "R10" : "R11";
      step(40);
    end
    cur_req = "R6";
    sync_ext_i = 1; ext_sel_i = 0;
    step(120);
    rand_pins = 0; fsr_i = 0;
    cur_req = "R1";
    sync_ext_i = 0; ext_sel_i = 1; ext_run = 1; clk_div_i = 2; fs_per_i = 3; fs_wid_i = 0;
    step(60);
    edge_count = 0;
    step(180);                                        // 30 ext ticks -> 10 CLKG
    cmp("ext edge count", "R1", edge_count, 10);
    cur_req = "R7";
    sync_ext_i = 1; clk_div_i = 4; fs_wid_i = 1;
    for (int k = 0; k < 8; k++) begin
      fsr_i = 1; step(14);
      fsr_i = 0; step(40 + 9 * k);
    end
    cur_req = "R8";
    gen_en_i = 0; step(40);
    gen_en_i = 1; step(80);
    step(2);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule